// File: doc/BRIEF.md
# PRBS Pattern Generator and Checker

This block is a test traffic source and a matching receiver for a parallel serial-link datapath. The generator produces one W-bit word per clock. The word carries one of seven pseudo-random sequences, a repeating user word, or a square-wave pattern with a selectable run length. Each source can go out as plain binary (NRZ) or as Gray-coded two-bit PAM4 symbols.

The checker takes the received word under the same configuration. For the pseudo-random sequences it seeds its own shift register from the incoming bits. For the fixed patterns it slides its reference until the data lines up. Once it has lock, it counts mismatched bits in a saturating counter.

In the intended use the generator output is looped back, through the datapath under test, to the checker input. A change to any configuration field restarts both halves.

Top module: `patgen_chk`

## Requirements
- R1: `cfg_sel` codes 0 to 6 select the sequences of order 7, 9, 11, 13, 23, 31 and 58. Their recurrences are x^7+x^6+1, x^9+x^5+1, x^11+x^9+1, x^13+x^12+x^2+x+1, x^23+x^18+1, x^31+x^28+1 and x^58+x^39+1. Each word holds W consecutive sequence bits, the earliest bit at the MSB, and the sequence restarts from an all-ones seed.
- R2: With `cfg_pam4` high, each pair of raw bits (a then b) at positions [2k+1:2k] is sent as the code {a, a XOR b}. This gives 00 as 0, 01 as 1, 11 as 2 and 10 as 3. The first pair sits at the top of the word.
- R3: `cfg_sel` code 7 repeats the low P bits of `usr_pat`, most significant first, where `cfg_ulen` 0 gives P=32, 1 gives P=64, and 2 or 3 give P=128.
- R4: `cfg_sel` codes 8 to 15 give alternating runs of L ones then L zeros. `cfg_arun` 0 gives L=1, 1 gives L=8, and 2 or 3 give L=64.
- R5: After reset, and in the cycle after any change to `cfg_sel`, `cfg_pam4`, `cfg_ulen` or `cfg_arun`, `gen_data` is zero. In the following cycle the selected pattern starts from its beginning. The sequence register is never all-zero.
- R6: With the output looped back, the checker raises `chk_lock` after 16 consecutive error-free words. For fixed patterns it first hunts for the alignment.
- R7: While locked, `chk_errs` grows by the number of mismatched raw bits in each word. In PAM4, a flipped low code bit counts 1 error and a flipped high code bit counts 2.
- R8: Lock drops after 8 consecutive words that each contain an error. A clean word resets that run.
- R9: `chk_errs` saturates at 2^ERR_W-1 and never wraps.
- R10: `err_clr` zeroes `chk_errs` at the next edge. It takes priority over any count in the same cycle.
- R11: While unlocked, `chk_errs` does not change. A configuration change clears `chk_lock` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 4 | Pattern select |
| cfg_pam4 | input | 1 | 1 = PAM4 Gray symbols, 0 = NRZ bits |
| cfg_ulen | input | 2 | User pattern length select |
| cfg_arun | input | 2 | Alternating run length select |
| usr_pat | input | 128 | User pattern bits |
| err_clr | input | 1 | Clear error counter |
| gen_data | output | W | Generated word |
| rx_data | input | W | Received word for the checker |
| chk_lock | output | 1 | Checker locked |
| chk_errs | output | ERR_W | Saturating bit error count |

## Verification
Driving the checker out of lock, or to its saturation limit, is the hardest thing to reach from the ports, because a healthy loopback never produces errors. The bench inserts an XOR mask between `gen_data` and `rx_data`. Single-bit, two-code-bit and full-word flips are timed to the exact words needed to reach the limits: seven errored words then a clean one, eight in a row, and full-word bursts that carry a narrow counter past its maximum. Relock after a corrupted unlocked stretch and the alignment hunt for each fixed pattern are covered by sweeping every select code in both encodings.

// File: rtl/patgen_pkg.sv
package patgen_pkg;

    localparam int LFSR_W = 58;
    localparam int FIX_W  = 128;

    typedef enum logic [3:0] {
        SEL_P7   = 4'd0,
        SEL_P9   = 4'd1,
        SEL_P11  = 4'd2,
        SEL_P13  = 4'd3,
        SEL_P23  = 4'd4,
        SEL_P31  = 4'd5,
        SEL_P58  = 4'd6,
        SEL_USER = 4'd7,
        SEL_ALT  = 4'd8
    } pat_e;

    typedef struct packed {
        pat_e       sel;
        logic       pam4;
        logic [1:0] ulen;
        logic [1:0] arun;
    } cfg_t;

    function automatic bit is_prbs(pat_e s);
        return s < SEL_USER;
    endfunction

    function automatic int order_of(pat_e s);
        case (s)
            SEL_P7:  return 7;
            SEL_P9:  return 9;
            SEL_P11: return 11;
            SEL_P13: return 13;
            SEL_P23: return 23;
            SEL_P31: return 31;
            SEL_P58: return 58;
            default: return 7;
        endcase
    endfunction

    // all-ones over the active order; also used as the seed
    function automatic logic [LFSR_W-1:0] order_mask(pat_e s);
        return (LFSR_W'(1) << order_of(s)) - LFSR_W'(1);
    endfunction

    // newest bit at index 0, bit k is k+1 steps old
    function automatic logic lfsr_fb(logic [LFSR_W-1:0] s, pat_e sel);
        case (sel)
            SEL_P7:  return s[6]  ^ s[5];
            SEL_P9:  return s[8]  ^ s[4];
            SEL_P11: return s[10] ^ s[8];
            SEL_P13: return s[12] ^ s[11] ^ s[1] ^ s[0];
            SEL_P23: return s[22] ^ s[17];
            SEL_P31: return s[30] ^ s[27];
            SEL_P58: return s[57] ^ s[38];
            default: return 1'b0;
        endcase
    endfunction

    function automatic int user_period(logic [1:0] code);
        case (code)
            2'd0:    return 32;
            2'd1:    return 64;
            default: return 128;
        endcase
    endfunction

    function automatic int run_length(logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 8;
            default: return 64;
        endcase
    endfunction

    // 128-bit window of a periodic stream, stream position 0 at the MSB
    function automatic logic [FIX_W-1:0] fixed_pattern(pat_e sel, logic [1:0] ulen,
                                                       logic [1:0] arun,
                                                       logic [FIX_W-1:0] usr);
        logic [FIX_W-1:0] p;
        int per;
        int run;
        p   = '0;
        per = user_period(ulen);
        run = run_length(arun);
        for (int i = 0; i < FIX_W; i++) begin
            if (sel == SEL_USER) p[FIX_W-1-i] = usr[per-1-(i % per)];
            else                 p[FIX_W-1-i] = ((i / run) % 2) == 0;
        end
        return p;
    endfunction

    function automatic logic [FIX_W-1:0] rotl(logic [FIX_W-1:0] v, int n);
        if (n <= 0 || n >= FIX_W) return v;
        return (v << n) | (v >> (FIX_W - n));
    endfunction

endpackage

// File: rtl/pam4_gray.sv
// Pairwise Gray code {a, a^b}; the same network also inverts it.
module pam4_gray #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NSYM = W / 2;

    for (genvar k = 0; k < NSYM; k++) begin : g_sym
        assign dout[2*k+1] = din[2*k+1];
        assign dout[2*k]   = din[2*k+1] ^ din[2*k];
    end

    if ((W % 2) != 0) begin : g_odd
        assign dout[W-1] = din[W-1];
    end
endmodule

// File: rtl/patgen_tx.sv
module patgen_tx
    import patgen_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    input  logic [FIX_W-1:0] usr_pat,
    input  logic             reload,
    output logic [W-1:0]     gen_data,
    output logic [LFSR_W-1:0] lfsr_st
);
    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [FIX_W-1:0]  fix;
        logic [W-1:0]      word;
        logic              pam4;
    } tx_s;

    tx_s d, q;
    logic [LFSR_W-1:0] s, m;
    logic              fb;
    logic [W-1:0]      mapped;

    always_comb begin
        d      = q;
        d.pam4 = cfg.pam4;
        m      = order_mask(cfg.sel);
        s      = q.lfsr;
        fb     = 1'b0;
        if (reload) begin
            d.lfsr = m;
            d.fix  = fixed_pattern(cfg.sel, cfg.ulen, cfg.arun, usr_pat);
            d.word = '0;
        end else if (is_prbs(cfg.sel)) begin
            for (int i = 0; i < W; i++) begin
                fb             = lfsr_fb(s, cfg.sel);
                d.word[W-1-i]  = fb;
                s              = ((s << 1) | LFSR_W'(fb)) & m;
            end
            d.lfsr = s;
        end else begin
            d.word = q.fix[FIX_W-1 -: W];
            d.fix  = rotl(q.fix, W);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lfsr <= order_mask(SEL_P7);
            q.fix  <= '0;
            q.word <= '0;
            q.pam4 <= 1'b0;
        end else begin
            q <= d;
        end
    end

    pam4_gray #(.W(W)) u_map (
        .din  (q.word),
        .dout (mapped)
    );

    assign gen_data = q.pam4 ? mapped : q.word;
    assign lfsr_st  = q.lfsr;
endmodule

// File: rtl/patgen_rx.sv
module patgen_rx
    import patgen_pkg::*;
#(
    parameter int W         = 32,
    parameter int ERR_W     = 16,
    parameter int LOCK_GOOD = 16,
    parameter int LOCK_BAD  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    input  logic [FIX_W-1:0] usr_pat,
    input  logic             reload,
    input  logic             err_clr,
    input  logic [W-1:0]     rx_data,
    output logic             lock,
    output logic [ERR_W-1:0] errs
);
    localparam int CW   = $clog2(W + 1);
    localparam int GW   = $clog2(LOCK_GOOD + 1);
    localparam int BW   = $clog2(LOCK_BAD + 1);
    localparam int HUNT = (W + 1) % FIX_W;

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [FIX_W-1:0]  fix;
        logic              lock;
        logic [GW-1:0]     good;
        logic [BW-1:0]     bad;
        logic [ERR_W-1:0]  errs;
    } rx_s;

    rx_s d, q;
    logic [W-1:0]      rx_dm, rx_bits, pred, mism;
    logic [LFSR_W-1:0] sp, sr, m;
    logic              fb, seeded, match;
    logic [CW-1:0]     nerr;
    logic [ERR_W:0]    sum;

    pam4_gray #(.W(W)) u_demap (
        .din  (rx_data),
        .dout (rx_dm)
    );

    assign rx_bits = cfg.pam4 ? rx_dm : rx_data;

    always_comb begin
        d      = q;
        m      = order_mask(cfg.sel);
        sp     = q.lfsr;
        sr     = q.lfsr;
        fb     = 1'b0;
        pred   = '0;
        seeded = 1'b1;
        sum    = '0;

        // prediction from own state; history built from received bits
        if (is_prbs(cfg.sel)) begin
            for (int i = 0; i < W; i++) begin
                fb            = lfsr_fb(sp, cfg.sel);
                pred[W-1-i]   = fb;
                sp            = ((sp << 1) | LFSR_W'(fb)) & m;
                sr            = ((sr << 1) | LFSR_W'(rx_bits[W-1-i])) & m;
            end
            seeded = (q.lfsr & m) != '0;
        end else begin
            pred = q.fix[FIX_W-1 -: W];
        end

        mism  = pred ^ rx_bits;
        nerr  = CW'($countones(mism));
        match = (nerr == '0);

        if (is_prbs(cfg.sel)) d.lfsr = q.lock ? sp : sr;
        else                  d.fix  = (q.lock || match) ? rotl(q.fix, W) : rotl(q.fix, HUNT);

        if (!q.lock) begin
            if (match && seeded) begin
                if (q.good == GW'(LOCK_GOOD - 1)) begin
                    d.lock = 1'b1;
                    d.good = '0;
                    d.bad  = '0;
                end else begin
                    d.good = q.good + GW'(1);
                end
            end else begin
                d.good = '0;
            end
        end else begin
            sum    = {1'b0, q.errs} + (ERR_W + 1)'(nerr);
            d.errs = sum[ERR_W] ? '1 : sum[ERR_W-1:0];
            if (!match) begin
                if (q.bad == BW'(LOCK_BAD - 1)) begin
                    d.lock = 1'b0;
                    d.bad  = '0;
                    d.good = '0;
                end else begin
                    d.bad = q.bad + BW'(1);
                end
            end else begin
                d.bad = '0;
            end
        end

        if (reload) begin
            d.lfsr = '0;
            d.fix  = fixed_pattern(cfg.sel, cfg.ulen, cfg.arun, usr_pat);
            d.lock = 1'b0;
            d.good = '0;
            d.bad  = '0;
            d.errs = q.errs;
        end

        if (err_clr) d.errs = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lfsr <= '0;
            q.fix  <= '0;
            q.lock <= 1'b0;
            q.good <= '0;
            q.bad  <= '0;
            q.errs <= '0;
        end else begin
            q <= d;
        end
    end

    assign lock = q.lock;
    assign errs = q.errs;
endmodule

// File: rtl/patgen_chk.sv
module patgen_chk
    import patgen_pkg::*;
#(
    parameter int W         = 32,
    parameter int ERR_W     = 16,
    parameter int LOCK_GOOD = 16,
    parameter int LOCK_BAD  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cfg_sel,
    input  logic             cfg_pam4,
    input  logic [1:0]       cfg_ulen,
    input  logic [1:0]       cfg_arun,
    input  logic [127:0]     usr_pat,
    input  logic             err_clr,
    output logic [W-1:0]     gen_data,
    input  logic [W-1:0]     rx_data,
    output logic             chk_lock,
    output logic [ERR_W-1:0] chk_errs
);
    typedef struct packed {
        cfg_t cfg;
    } top_s;

    top_s              d, q;
    cfg_t              cfg_in;
    logic              reload;
    logic [LFSR_W-1:0] gen_lfsr;
    pat_e              sel_q;

    assign cfg_in = '{sel: pat_e'(cfg_sel), pam4: cfg_pam4, ulen: cfg_ulen, arun: cfg_arun};
    assign reload = (cfg_in != q.cfg);
    assign sel_q  = q.cfg.sel;

    always_comb begin
        d     = q;
        d.cfg = cfg_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.cfg <= '{sel: SEL_P7, pam4: 1'b0, ulen: 2'd0, arun: 2'd0};
        else        q     <= d;
    end

    patgen_tx #(.W(W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg_in),
        .usr_pat  (usr_pat),
        .reload   (reload),
        .gen_data (gen_data),
        .lfsr_st  (gen_lfsr)
    );

    patgen_rx #(
        .W         (W),
        .ERR_W     (ERR_W),
        .LOCK_GOOD (LOCK_GOOD),
        .LOCK_BAD  (LOCK_BAD)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg_in),
        .usr_pat (usr_pat),
        .reload  (reload),
        .err_clr (err_clr),
        .rx_data (rx_data),
        .lock    (chk_lock),
        .errs    (chk_errs)
    );
endmodule

// File: rtl/patgen_chk_sva.sv
module patgen_chk_sva
    import patgen_pkg::*;
#(
    parameter int W     = 32,
    parameter int ERR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reload,
    input logic              err_clr,
    input logic              lock,
    input logic [ERR_W-1:0]  errs,
    input logic [W-1:0]      gen_data,
    input logic [LFSR_W-1:0] lfsr_st,
    input pat_e              sel_q
);
    // R5
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_prbs(sel_q) |-> ((lfsr_st & order_mask(sel_q)) != '0));

    // R5
    restart_zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (gen_data == '0));

    // R11
    reload_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !lock);

    // R11
    idle_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && !err_clr) |=> $stable(errs));

    // R9
    count_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> (errs >= $past(errs)));

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (errs == '0));
endmodule

bind patgen_chk patgen_chk_sva #(.W(W), .ERR_W(ERR_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload   (reload),
    .err_clr  (err_clr),
    .lock     (chk_lock),
    .errs     (chk_errs),
    .gen_data (gen_data),
    .lfsr_st  (gen_lfsr),
    .sel_q    (sel_q)
);

// File: tb/tb_patgen_chk.sv
module tb_patgen_chk;
    localparam int W     = 32;
    localparam int EW    = 8;
    localparam int CLK_P = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [3:0]     cfg_sel = 4'd0;
    logic           cfg_pam4 = 1'b0;
    logic [1:0]     cfg_ulen = 2'd0;
    logic [1:0]     cfg_arun = 2'd0;
    logic [127:0]   usr_pat = 128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;
    logic           err_clr = 1'b0;
    logic [W-1:0]   gen_data;
    logic [W-1:0]   inj = '0;
    logic [W-1:0]   rx_data;
    logic           chk_lock;
    logic [EW-1:0]  chk_errs;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] m_st;
    int m_ord, m_k, cur_sel, cur_ulen, cur_arun;
    bit cur_pam;

    always #(CLK_P/2) clk = ~clk;
    assign rx_data = gen_data ^ inj;

    patgen_chk #(.W(W), .ERR_W(EW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_pam4(cfg_pam4),
        .cfg_ulen(cfg_ulen), .cfg_arun(cfg_arun), .usr_pat(usr_pat),
        .err_clr(err_clr), .gen_data(gen_data), .rx_data(rx_data),
        .chk_lock(chk_lock), .chk_errs(chk_errs)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ord_for(int s);
        case (s)
            0: return 7;  1: return 9;  2: return 11; 3: return 13;
            4: return 23; 5: return 31; default: return 58;
        endcase
    endfunction

    function automatic logic nfb(logic [63:0] s, int n);
        case (n)
            7:  return s[6] ^ s[5];
            9:  return s[8] ^ s[4];
            11: return s[10] ^ s[8];
            13: return s[12] ^ s[11] ^ s[1] ^ s[0];
            23: return s[22] ^ s[17];
            31: return s[30] ^ s[27];
            default: return s[57] ^ s[38];
        endcase
    endfunction

    function automatic logic stream_bit(int p);
        int per, run;
        if (cur_sel == 7) begin
            per = (cur_ulen == 0) ? 32 : (cur_ulen == 1) ? 64 : 128;
            return usr_pat[per-1-(p % per)];
        end
        run = (cur_arun == 0) ? 1 : (cur_arun == 1) ? 8 : 64;
        return ((p / run) % 2) == 0;
    endfunction

    function automatic logic [W-1:0] pam_map(logic [W-1:0] w);
        logic [W-1:0] r;
        for (int k = 0; k < W/2; k++) begin
            r[2*k+1] = w[2*k+1];
            r[2*k]   = w[2*k+1] ^ w[2*k];
        end
        return r;
    endfunction

    task automatic next_exp(output logic [W-1:0] e);
        logic f;
        e = '0;
        if (cur_sel < 7) begin
            for (int j = 0; j < W; j++) begin
                f = nfb(m_st, m_ord);
                e[W-1-j] = f;
                m_st = ((m_st << 1) | 64'(f)) & ((64'd1 << m_ord) - 64'd1);
            end
        end else begin
            for (int j = 0; j < W; j++) e[W-1-j] = stream_bit(m_k * W + j);
            m_k++;
        end
        if (cur_pam) e = pam_map(e);
    endtask

    task automatic set_cfg(input int s, input bit p, input int ul, input int ar);
        @(negedge clk);
        cfg_sel = 4'(s); cfg_pam4 = p; cfg_ulen = 2'(ul); cfg_arun = 2'(ar);
        cur_sel = s; cur_pam = p; cur_ulen = ul; cur_arun = ar;
        m_ord = ord_for(s);
        m_st = (64'd1 << m_ord) - 64'd1;
        m_k = 0;
        @(negedge clk);
        chk(gen_data == '0, "R5 zero word after config change", gen_data, 0);
        chk(chk_lock == 1'b0, "R11 lock cleared by config change", chk_lock, 0);
    endtask

    task automatic clear_errs();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(chk_errs == '0, "R10 clear", chk_errs, 0);
    endtask

    task automatic run_cfg(input int s, input bit p, input int ul, input int ar, input int wait_n);
        logic [W-1:0] e;
        string tag;
        set_cfg(s, p, ul, ar);
        tag = (s < 7) ? (p ? "R2 PAM4 sequence word" : "R1 NRZ sequence word") :
              ((s == 7) ? "R3 user pattern word" : "R4 alternating word");
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            next_exp(e);
            chk(gen_data == e, tag, gen_data, e);
        end
        clear_errs();
        repeat (wait_n) @(negedge clk);
        chk(chk_lock == 1'b1, "R6 lock on clean loopback", chk_lock, 1);
        chk(chk_errs == '0, "R6 no errors on clean loopback", chk_errs, 0);
    endtask

    task automatic inj_words(input logic [W-1:0] mask, input int n);
        inj = mask;
        repeat (n) @(negedge clk);
        inj = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(gen_data == '0, "R5 reset word", gen_data, 0);
        chk(chk_lock == 1'b0, "R11 reset lock", chk_lock, 0);
        chk(chk_errs == '0, "R9 reset count", chk_errs, 0);
        rst_n = 1'b1;

        for (int s = 0; s < 7; s++) begin
            run_cfg(s, 1'b1, 0, 0, 60);
            run_cfg(s, 1'b0, 0, 0, 60);
        end
        for (int u = 0; u < 3; u++) run_cfg(7, 1'b0, u, 0, 600);
        run_cfg(7, 1'b1, 2, 0, 600);
        for (int a = 0; a < 3; a++) run_cfg(9 + a, 1'b0, 0, a, 600);
        run_cfg(8, 1'b0, 1, 1, 600);

        // R7 bit error counting in NRZ
        run_cfg(5, 1'b0, 0, 0, 60);
        inj_words(32'h8000_0101, 1);
        @(negedge clk);
        chk(chk_errs == 8'd3, "R7 three flipped bits", chk_errs, 3);
        chk(chk_lock == 1'b1, "R8 one bad word keeps lock", chk_lock, 1);

        // R8 seven bad then clean keeps lock, eight in a row drops it
        clear_errs();
        inj_words(32'h0000_0010, 7);
        @(negedge clk);
        chk(chk_lock == 1'b1, "R8 seven errored words keep lock", chk_lock, 1);
        inj_words(32'h0000_0010, 8);
        chk(chk_lock == 1'b0, "R8 eight errored words drop lock", chk_lock, 0);
        chk(chk_errs == 8'd15, "R7 errors counted while locked", chk_errs, 15);
        inj_words('1, 3);
        @(negedge clk);
        chk(chk_errs == 8'd15, "R11 no count while unlocked", chk_errs, 15);
        repeat (100) @(negedge clk);
        chk(chk_lock == 1'b1, "R6 relock after disturbance", chk_lock, 1);
        chk(chk_errs == 8'd15, "R11 count held through relock", chk_errs, 15);

        // R9 saturation, R10 clear priority
        clear_errs();
        inj_words('1, 7);
        chk(chk_errs == 8'd224, "R7 full word flips", chk_errs, 224);
        @(negedge clk);
        inj_words('1, 2);
        chk(chk_errs == 8'd255, "R9 saturation", chk_errs, 255);
        chk(chk_lock == 1'b1, "R8 clean word resets bad run", chk_lock, 1);
        inj = '1; err_clr = 1'b1;
        @(negedge clk);
        inj = '0; err_clr = 1'b0;
        chk(chk_errs == '0, "R10 clear beats count", chk_errs, 0);

        // R7 PAM4 code bit weights
        run_cfg(3, 1'b1, 0, 0, 60);
        inj_words(32'h0000_0001, 1);
        @(negedge clk);
        chk(chk_errs == 8'd1, "R7 PAM4 low code bit", chk_errs, 1);
        inj_words(32'h0000_0002, 1);
        @(negedge clk);
        chk(chk_errs == 8'd3, "R7 PAM4 high code bit", chk_errs, 3);

        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end
endmodule